// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block stores a small array of packed predicate configuration entries and uses them to find the predicate that belongs to an instruction operand. Software writes entries through a plain configuration write port. The block treats the array as two derived predicate tables, one for integer registers and one for floating-point registers, each indexed by a 5-bit register key. To form the tables it scans the entries in index order. The scan stops at the first all-zero entry. Where two entries hit the same key and table, the later one wins.

A lookup request carries the original, non-redirected register number, the register type, and the active flag of that register's redirection entry. In the same cycle the block drives the predicate register index onto a register-file read port and samples the value that comes back. One cycle later it returns the mask, the zeroing flag and the predicate register index.

Both the request and the response use valid/ready handshakes. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `resp_valid` is high and `resp_ready` is low, the response holds steady and no new request is taken.

Top module: `pred_mask_unit`

## Requirements
- R1: A configuration entry is 15 bits wide:
  - key in bits 4:0
  - zeroing flag in bit 5
  - inversion flag in bit 6
  - type in bit 7 (1 = integer table, 0 = floating-point table)
  - predicate register index in bits 13:8
  - active flag in bit 14
- R2: Writing entry k sets entry k to the written value and clears every entry with an index above k in the same clock.
- R3: Only entries before the first all-zero entry take part in a lookup. An entry placed after a zero gap is ignored.
- R4: A lookup sees only entries whose type bit matches the requested type.
- R5: When several entries before the stop point match the same key and type, the one with the highest index is used.
- R6: If the request's redirection-active input is 0, the response mask is all ones, the zeroing output is 0 and the returned index is 0.
- R7: If no matching entry exists, or the matching entry's active bit is 0, the response mask is all ones, the zeroing output is 0 and the returned index is 0.
- R8: For an active match with redirection active:
  - `rf_ridx` carries the entry's predicate index in the request cycle.
  - The response carries the register value that was sampled in that cycle.
  - The response also carries the entry's zeroing flag (1 = zero masked-off elements, 0 = skip them) and its index.
- R9: For an active match whose inversion flag is 1, the response mask is the bitwise complement of the sampled register value.
- R10: A request is accepted when `req_valid` and `req_ready` are both high, and its response appears with `resp_valid` on the next cycle. While `resp_valid` is high and `resp_ready` is low, `req_ready` is low and the response outputs stay unchanged.
- R11: After reset, `resp_valid` is 0 and all entries are zero, so every lookup falls back to the all-ones mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_idx | input | IDX_W | Entry index written |
| cfg_wdata | input | 15 | Packed entry value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_key | input | 5 | Original operand register number |
| req_is_int | input | 1 | 1 = integer operand, 0 = floating-point |
| req_redir_active | input | 1 | Active flag of the operand's redirection entry |
| rf_ridx | output | 6 | Predicate register read index |
| rf_rdata | input | MASK_W | Predicate register value, combinational reply |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumed |
| resp_mask | output | MASK_W | Element mask |
| resp_zero | output | 1 | 1 = zero masked-off elements, 0 = skip |
| resp_pidx | output | 6 | Predicate register index used |

## Verification
Lookups are tried with several inputs:
- A fresh integer entry and the same key in the floating-point table, which separates the two tables.
- An inverted entry, which shows complement and pass-through apart.
- An inactive entry and an inactive redirection flag, which show the two fallback paths.
- A later duplicate key, which tests priority.

Rewrites at a low index show whether the higher entries are cleared. An entry placed behind a zero gap shows whether the scan stops there. A stalled response with a changed pending request shows that back-pressure holds both sides.

// File: rtl/pml_pkg.sv
package pml_pkg;
  localparam int KEY_W   = 5;
  localparam int PIDX_W  = 6;
  localparam int ENTRY_W = 15;

  typedef struct packed {
    logic              active;
    logic [PIDX_W-1:0] pidx;
    logic              is_int;
    logic              inv;
    logic              zero;
    logic [KEY_W-1:0]  key;
  } pred_cfg_t;
endpackage

// File: rtl/pml_cfg_array.sv
module pml_cfg_array
  import pml_pkg::*;
#(
  parameter int NUM   = 16,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [ENTRY_W-1:0]     wdata,
  output logic [NUM*ENTRY_W-1:0] flat
);
  for (genvar g = 0; g < NUM; g++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (we) begin
        if (g == int'(idx))     ent_q <= wdata;
        else if (g > int'(idx)) ent_q <= '0;
      end
    end
    assign flat[g*ENTRY_W +: ENTRY_W] = ent_q;
  end
endmodule

// File: rtl/pml_pred_scan.sv
module pml_pred_scan
  import pml_pkg::*;
#(
  parameter int NUM = 16
) (
  input  logic [NUM*ENTRY_W-1:0] flat,
  input  logic [KEY_W-1:0]       q_key,
  input  logic                   q_int,
  output logic                   hit,
  output pred_cfg_t              ent
);
  always_comb begin
    logic stop;
    pred_cfg_t e;
    stop = 1'b0;
    hit  = 1'b0;
    ent  = '0;
    for (int i = 0; i < NUM; i++) begin
      e = pred_cfg_t'(flat[i*ENTRY_W +: ENTRY_W]);
      if (e == '0) stop = 1'b1;
      if (!stop && e.key == q_key && e.is_int == q_int) begin
        hit = 1'b1;
        ent = e;
      end
    end
  end
endmodule

// File: rtl/pml_mask_gen.sv
module pml_mask_gen
  import pml_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input  logic              redir_active,
  input  logic              hit,
  input  pred_cfg_t         ent,
  input  logic [MASK_W-1:0] rdata,
  output logic [MASK_W-1:0] mask,
  output logic              zero,
  output logic [PIDX_W-1:0] pidx
);
  logic use_pred;
  assign use_pred = redir_active && hit && ent.active;

  always_comb begin
    if (use_pred) begin
      mask = ent.inv ? ~rdata : rdata;
      zero = ent.zero;
      pidx = ent.pidx;
    end else begin
      mask = '1;
      zero = 1'b0;
      pidx = '0;
    end
  end
endmodule

// File: rtl/pred_mask_unit.sv
module pred_mask_unit
  import pml_pkg::*;
#(
  parameter int NUM    = 16,
  parameter int MASK_W = 64,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [14:0]        cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [4:0]         req_key,
  input  logic               req_is_int,
  input  logic               req_redir_active,
  output logic [5:0]         rf_ridx,
  input  logic [MASK_W-1:0]  rf_rdata,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [MASK_W-1:0]  resp_mask,
  output logic               resp_zero,
  output logic [5:0]         resp_pidx
);
  logic [NUM*ENTRY_W-1:0] cfg_flat;
  logic                   hit;
  pred_cfg_t              ent;
  logic [MASK_W-1:0]      mask_d;
  logic                   zero_d;
  logic [PIDX_W-1:0]      pidx_d;
  logic                   accept;

  pml_cfg_array #(.NUM(NUM)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .flat(cfg_flat)
  );

  pml_pred_scan #(.NUM(NUM)) u_scan (
    .flat(cfg_flat), .q_key(req_key), .q_int(req_is_int),
    .hit(hit), .ent(ent)
  );

  pml_mask_gen #(.MASK_W(MASK_W)) u_gen (
    .redir_active(req_redir_active), .hit(hit), .ent(ent),
    .rdata(rf_rdata), .mask(mask_d), .zero(zero_d), .pidx(pidx_d)
  );

  assign rf_ridx   = ent.pidx;
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_mask  <= '0;
      resp_zero  <= 1'b0;
      resp_pidx  <= '0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_mask  <= mask_d;
      resp_zero  <= zero_d;
      resp_pidx  <= pidx_d;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pml_chk.sv
module pml_chk #(
  parameter int NUM    = 16,
  parameter int MASK_W = 64,
  parameter int IDX_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [IDX_W-1:0]    cfg_idx,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_redir_active,
  input logic                resp_valid,
  input logic                resp_ready,
  input logic [MASK_W-1:0]   resp_mask,
  input logic                resp_zero,
  input logic [5:0]          resp_pidx,
  input logic [NUM*15-1:0]   cfg_flat
);
  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_mask)
      && $stable(resp_zero) && $stable(resp_pidx));

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  a_r6_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_redir_active |=> resp_mask == '1
      && !resp_zero && resp_pidx == '0);

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_idx == '0 |=> cfg_flat[NUM*15-1:15] == '0);
endmodule

bind pred_mask_unit pml_chk #(.NUM(NUM), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_redir_active(req_redir_active), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .resp_mask(resp_mask), .resp_zero(resp_zero),
  .resp_pidx(resp_pidx), .cfg_flat(cfg_flat)
);

// File: tb/sim_pred_mask_unit.sv
module sim_pred_mask_unit;
  localparam int NUM = 16, MASK_W = 64, IDX_W = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [14:0] cfg_wdata = '0;
  logic req_valid = 0, req_is_int = 0, req_redir_active = 0, resp_ready = 1;
  logic [4:0] req_key = '0;
  logic req_ready, resp_valid, resp_zero;
  logic [5:0] rf_ridx, resp_pidx;
  logic [MASK_W-1:0] rf_rdata, resp_mask;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  function automatic logic [MASK_W-1:0] rfv(input logic [5:0] i);
    return {4'h0, {10{i}}} ^ 64'hA5A5_0000_FFFF_1234;
  endfunction
  assign rf_rdata = rfv(rf_ridx);

  pred_mask_unit #(.NUM(NUM), .MASK_W(MASK_W)) u0 (.*);

  function automatic logic [14:0] mk(input logic [4:0] key, input logic z,
      input logic inv, input logic ti, input logic [5:0] p, input logic act);
    return {act, p, ti, inv, z, key};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [14:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic look(input string req, input logic ti, input logic [4:0] key,
      input logic redir, input logic [MASK_W-1:0] em, input logic ez, input logic [5:0] ep);
    @(negedge clk);
    req_valid = 1; req_is_int = ti; req_key = key; req_redir_active = redir;
    @(negedge clk);
    req_valid = 0;
    chk(req, {63'b0, resp_valid}, 128'd1);
    chk(req, {56'b0, resp_mask, 1'b0, resp_zero, resp_pidx},
             {56'b0, em, 1'b0, ez, ep});
  endtask

  task automatic t_reset;
    chk("R11 valid", {126'b0, resp_valid, req_ready}, 128'd1);
    look("R11/R7 empty", 1, 5'd3, 1, '1, 0, 0);
  endtask

  task automatic t_basic;
    wr(0, mk(5'd3, 1, 0, 1, 6'd9, 1));
    @(negedge clk); req_is_int = 1; req_key = 5'd3; #1;
    chk("R8 rf_ridx", {122'b0, rf_ridx}, 128'd9);
    look("R1/R8 int hit", 1, 5'd3, 1, rfv(6'd9), 1, 6'd9);
    look("R4 fp miss", 0, 5'd3, 1, '1, 0, 0);
  endtask

  task automatic t_invert;
    wr(1, mk(5'd7, 0, 1, 0, 6'd20, 1));
    look("R9 invert", 0, 5'd7, 1, ~rfv(6'd20), 0, 6'd20);
  endtask

  task automatic t_redir;
    look("R6 redir off", 1, 5'd3, 0, '1, 0, 0);
  endtask

  task automatic t_inactive;
    wr(2, mk(5'd12, 1, 0, 1, 6'd5, 0));
    look("R7 inactive", 1, 5'd12, 1, '1, 0, 0);
  endtask

  task automatic t_override;
    wr(3, mk(5'd3, 0, 0, 1, 6'd40, 1));
    look("R5 later wins", 1, 5'd3, 1, rfv(6'd40), 0, 6'd40);
  endtask

  task automatic t_clear;
    wr(1, mk(5'd30, 0, 0, 1, 6'd2, 1));
    look("R2 upper cleared", 1, 5'd3, 1, rfv(6'd9), 1, 6'd9);
    look("R2 old e1 gone", 0, 5'd7, 1, '1, 0, 0);
    look("R2 new e1", 1, 5'd30, 1, rfv(6'd2), 0, 6'd2);
  endtask

  task automatic t_stop;
    wr(0, mk(5'd1, 0, 0, 1, 6'd3, 1));
    wr(2, mk(5'd2, 0, 0, 1, 6'd4, 1));
    look("R3 after gap", 1, 5'd2, 1, '1, 0, 0);
    look("R3 before gap", 1, 5'd1, 1, rfv(6'd3), 0, 6'd3);
  endtask

  task automatic t_stall;
    @(negedge clk);
    resp_ready = 0; req_valid = 1; req_is_int = 1; req_key = 5'd1; req_redir_active = 1;
    @(negedge clk);
    req_key = 5'd9; req_redir_active = 0;
    chk("R10 valid", {127'b0, resp_valid}, 128'd1);
    chk("R10 not ready", {127'b0, req_ready}, 128'd0);
    @(negedge clk); @(negedge clk);
    chk("R10 held", {63'b0, resp_valid, resp_mask}, {63'b0, 1'b1, rfv(6'd3)});
    resp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 next resp", {63'b0, resp_valid, resp_mask}, {63'b0, 1'b1, {MASK_W{1'b1}}});
    @(negedge clk);
    chk("R10 drained", {127'b0, resp_valid}, 128'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_basic(); t_invert(); t_redir(); t_inactive();
    t_override(); t_clear(); t_stop(); t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule